// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Front End

This block is the slave side of a byte-wide memory attached to a microcontroller bus whose single 8-bit port carries first the low address byte and then the data byte. During the address phase the master holds the address strobe high and presents the low byte on the shared port and the upper seven bits on dedicated inputs. The front end follows those pins while the strobe is high and freezes the full 15-bit address when the strobe falls. After that the shared port can turn around and carry data.

In the data phase, chip select, the read/write level and the data strobe E are decoded into requests on a simple internal memory port. A read issues a one-cycle read request when E rises. The returned byte is then driven onto the shared port with its output enable until E falls. A write captures the byte on the shared port when E falls and issues a one-cycle write strobe with the held address. While chip select is low, the block stays silent. Every bus input passes through a two-flop synchronizer, and edges are found on the synchronized copies. The bus timing is therefore a few clocks slower than the internal clock.

Top module: `mbus_slave_front`

## Requirements
- R1: While the address strobe is high the address follows the bus pins; from its falling edge on, the address on `mem_addr` is held, and later changes on the shared port or the high address pins do not alter the address used by the following read or write.
- R2: With chip select high and R/W high (read), a rising edge of E produces exactly one single-cycle `mem_re` pulse and no write; while E stays high the byte returned on `mem_rdata` (valid one clock after `mem_re`) is driven on `bus_ad_out` with `bus_ad_oe` high.
- R3: Within five clocks after E falls, `bus_ad_oe` is low.
- R4: With chip select high and R/W low (write), a falling edge of E produces exactly one `mem_we` pulse, one clock wide, whose `mem_wdata` is the byte on the shared port when E fell.
- R5: While chip select is low, no `mem_we` or `mem_re` pulse is issued whatever E and R/W do, and `bus_ad_oe` is low from at most four clocks after chip select falls, even in the middle of a read.
- R6: The 15-bit address is formed with bits 7:0 from the shared port and bits 14:8 from `bus_addr_hi`; addresses 0x0000 and 0x7FFF are both reachable.
- R7: `mem_we` and `mem_re` are never high in the same cycle.
- R8: After synchronous reset `bus_ad_oe`, `mem_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ad_in | input | 8 | Shared port, input side (low address byte, then write data) |
| bus_ad_out | output | 8 | Shared port, read data to drive |
| bus_ad_oe | output | 1 | Output enable of the shared port |
| bus_addr_hi | input | 7 | Address bits 14:8 |
| bus_as | input | 1 | Address strobe, address followed while high |
| bus_e | input | 1 | Data strobe |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_cs | input | 1 | Chip select, active high |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one clock |
| mem_re | output | 1 | Memory read request, one clock |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_re |

## Verification
The assertions check several rules on every cycle. The held address stays still while the strobe is low. Read and write pulses are one clock wide and never overlap. A write pulse only follows a selected write. The output enable drops after an E fall and never stays up without chip select. Other behaviour only shows across a full bus transaction in the bench's scenarios: the address that reaches memory is the one latched, not the one later on the pins. Read data driven back matches earlier writes at both ends of the address space. A deselected write leaves memory untouched, and deselecting in the middle of a read releases the port.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_WAIT  = 2'd1,
    RD_LOAD  = 2'd2,
    RD_DRIVE = 2'd3
  } rd_state_t;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 7,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_s,
  input  logic [LO_W-1:0]   lo_s,
  input  logic [HI_W-1:0]   hi_s,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (as_s) addr <= {hi_s, lo_s};
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !as_s |=> $stable(addr)); // R1
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_s,
  input  logic              rw_s,
  input  logic              cs_s,
  input  logic [DATA_W-1:0] ad_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  logic      e_d;
  logic      e_rise, e_fall;
  rd_state_t st;

  always_comb begin
    e_rise = e_s & ~e_d;
    e_fall = ~e_s & e_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_d       <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      st        <= RD_IDLE;
    end else begin
      e_d    <= e_s;
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      if (e_fall && cs_s && !rw_s) begin
        mem_we    <= 1'b1;
        mem_wdata <= ad_s;
      end
      if (!cs_s || !rw_s || e_fall) begin
        st    <= RD_IDLE;
        ad_oe <= 1'b0;
      end else begin
        case (st)
          RD_IDLE: if (e_rise) begin
            mem_re <= 1'b1;
            st     <= RD_WAIT;
          end
          RD_WAIT: st <= RD_LOAD;
          RD_LOAD: begin
            ad_out <= mem_rdata;
            ad_oe  <= 1'b1;
            st     <= RD_DRIVE;
          end
          default: st <= RD_DRIVE;
        endcase
      end
    end
  end

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4
  AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re); // R2
  AST_NO_RE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R7
  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(cs_s && !rw_s)); // R5
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> $past(cs_s)); // R5
  AST_OE_DROP: assert property (@(posedge clk) disable iff (rst)
    e_fall |=> !ad_oe); // R3
endmodule

// File: rtl/mbus_slave_front.sv
module mbus_slave_front #(
  parameter int LO_W        = 8,
  parameter int HI_W        = 7,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LO_W-1:0]   bus_ad_in,
  output logic [LO_W-1:0]   bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [HI_W-1:0]   bus_addr_hi,
  input  logic              bus_as,
  input  logic              bus_e,
  input  logic              bus_rw,
  input  logic              bus_cs,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LO_W-1:0]   mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [LO_W-1:0]   mem_rdata
);
  localparam int SYNC_W = ADDR_W + 4;

  logic [SYNC_W-1:0] raw, syn;
  logic [LO_W-1:0]   ad_s;
  logic [HI_W-1:0]   hi_s;
  logic              as_s, e_s, rw_s, cs_s;

  assign raw = {bus_cs, bus_rw, bus_e, bus_as, bus_addr_hi, bus_ad_in};
  assign {cs_s, rw_s, e_s, as_s, hi_s, ad_s} = syn;

  mbus_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(syn)
  );

  mbus_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst(rst), .as_s(as_s), .lo_s(ad_s), .hi_s(hi_s), .addr(mem_addr)
  );

  mbus_ctrl #(.DATA_W(LO_W)) u_ctrl (
    .clk(clk), .rst(rst), .e_s(e_s), .rw_s(rw_s), .cs_s(cs_s), .ad_s(ad_s),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .ad_out(bus_ad_out), .ad_oe(bus_ad_oe)
  );
endmodule

// File: tb/mbus_slave_front_tb.sv
module mbus_slave_front_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ad_in = 8'h00;
  logic [6:0]  ahi = 7'h00;
  logic        as_p = 1'b0, e_p = 1'b0, rw_p = 1'b1, cs_p = 1'b0;
  logic [7:0]  ad_out, mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        oe, mem_we, mem_re;
  logic [14:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  int we_cnt = 0, re_cnt = 0, cs_low_cnt = 0;
  logic        we_prev = 1'b0, re_prev = 1'b0;
  logic [14:0] last_we_addr = '0, last_re_addr = '0;
  logic [7:0]  last_we_data = '0;
  logic [7:0]  dev_mem [logic [14:0]];
  logic [7:0]  ref_mem [logic [14:0]];

  always #10 clk = ~clk;

  mbus_slave_front u_dut (
    .clk(clk), .rst(rst), .bus_ad_in(ad_in), .bus_ad_out(ad_out), .bus_ad_oe(oe),
    .bus_addr_hi(ahi), .bus_as(as_p), .bus_e(e_p), .bus_rw(rw_p), .bus_cs(cs_p),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  // memory behind the front end: registered read, one clock latency
  always @(posedge clk) begin
    if (mem_we) dev_mem[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_rd(input logic [14:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  // per-clock reference checks, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(!(mem_we && mem_re), "R7 we/re overlap", {mem_we, mem_re}, 0);
      if (mem_we && we_prev) chk(1'b0, "R4 we width", 2, 1);
      if (mem_re && re_prev) chk(1'b0, "R2 re width", 2, 1);
      if (cs_low_cnt >= 4) chk(!oe, "R5 oe while deselected", oe, 0);
      if (cs_low_cnt >= 4) chk(!mem_we && !mem_re, "R5 request while deselected",
                               {mem_we, mem_re}, 0);
      if (mem_we) begin we_cnt++; last_we_addr = mem_addr; last_we_data = mem_wdata; end
      if (mem_re) begin re_cnt++; last_re_addr = mem_addr; end
    end
    we_prev = mem_we;
    re_prev = mem_re;
    cs_low_cnt = cs_p ? 0 : cs_low_cnt + 1;
  end

  task automatic bus_op(input bit cs, input bit rw, input logic [14:0] a, input logic [7:0] d);
    int we0, re0;
    @(negedge clk);
    as_p = 1'b1; cs_p = cs; rw_p = rw; e_p = 1'b0;
    ad_in = a[7:0]; ahi = a[14:8];
    repeat (4) @(negedge clk);
    as_p = 1'b0;
    repeat (3) @(negedge clk);
    // scramble the address pins after the strobe fall (R1)
    ad_in = rw ? ~a[7:0] : d;
    ahi = ~a[14:8];
    we0 = we_cnt; re0 = re_cnt;
    e_p = 1'b1;
    repeat (8) @(negedge clk);
    if (cs && rw) begin
      chk(oe == 1'b1, "R2 oe during read", oe, 1);
      chk(ad_out == ref_rd(a), "R2 read data", ad_out, ref_rd(a));
    end
    e_p = 1'b0;
    repeat (5) @(negedge clk);
    chk(!oe, "R3 oe after E fall", oe, 0);
    if (cs && !rw) begin
      chk(we_cnt == we0 + 1, "R4 write pulses", we_cnt - we0, 1);
      chk(last_we_addr == a, "R1 R6 write address", last_we_addr, a);
      chk(last_we_data == d, "R4 write data", last_we_data, d);
      chk(re_cnt == re0, "R7 no read on write", re_cnt - re0, 0);
      ref_mem[a] = d;
    end else if (cs && rw) begin
      chk(re_cnt == re0 + 1, "R2 read pulses", re_cnt - re0, 1);
      chk(last_re_addr == a, "R1 R6 read address", last_re_addr, a);
      chk(we_cnt == we0, "R2 no write on read", we_cnt - we0, 0);
    end else begin
      chk(we_cnt == we0 && re_cnt == re0, "R5 deselected access",
          (we_cnt - we0) + (re_cnt - re0), 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [14:0] addr_list [8];

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!oe, "R8 reset oe", oe, 0);
    chk(!mem_we && !mem_re, "R8 reset strobes", {mem_we, mem_re}, 0);

    // boundary and pattern writes, then read back
    bus_op(1, 0, 15'h0000, 8'h3C);   // R6 lowest address
    bus_op(1, 0, 15'h7FFF, 8'hC5);   // R6 highest address
    bus_op(1, 0, 15'h1234, 8'hA5);
    bus_op(1, 0, 15'h4B0F, 8'h96);
    bus_op(1, 1, 15'h0000, 8'h00);
    bus_op(1, 1, 15'h7FFF, 8'h00);
    bus_op(1, 1, 15'h1234, 8'h00);
    bus_op(1, 1, 15'h4B0F, 8'h00);
    bus_op(1, 1, 15'h0100, 8'h00);   // unwritten location

    // deselected write must not reach memory, deselected read stays silent (R5)
    bus_op(0, 0, 15'h1234, 8'hFF);
    bus_op(1, 1, 15'h1234, 8'h00);
    bus_op(0, 1, 15'h4B0F, 8'h00);

    // overwrite and read back
    bus_op(1, 0, 15'h1234, 8'h5B);
    bus_op(1, 1, 15'h1234, 8'h00);

    // chip select dropped in the middle of a read releases the port (R5)
    @(negedge clk);
    as_p = 1'b1; cs_p = 1'b1; rw_p = 1'b1; ad_in = 8'hFF; ahi = 7'h7F;
    repeat (4) @(negedge clk);
    as_p = 1'b0;
    repeat (3) @(negedge clk);
    e_p = 1'b1;
    repeat (8) @(negedge clk);
    chk(oe == 1'b1, "R2 oe before deselect", oe, 1);
    chk(ad_out == 8'hC5, "R2 data before deselect", ad_out, 8'hC5);
    cs_p = 1'b0;
    repeat (4) @(negedge clk);
    chk(!oe, "R5 oe after deselect", oe, 0);
    e_p = 1'b0;
    repeat (3) @(negedge clk);

    // walking pattern over the address space
    for (int i = 0; i < 8; i++) begin
      addr_list[i] = 15'(i * 15'h0F1F + 15'h0011);
      bus_op(1, 0, addr_list[i], 8'(8'h17 * i + 8'h0B));
    end
    for (int i = 0; i < 8; i++) bus_op(1, 1, addr_list[i], 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule